// File: doc/BRIEF.md
# 32-Pin GPIO Port with Per-Pin Interrupt Capture

This block is one general-purpose I/O port of 32 pins, controlled through a small 32-bit register interface with byte addresses. Software programs an output level and a drive enable for each pin, either by writing whole words or through write-only set and clear aliases. These aliases change only the bits written as 1, so no read-modify-write is needed. The pin levels are brought into the clock domain by a two-stage synchroniser and can be read back.

Every pin has its own event detector. It can be set to edge or level sensing, with positive or negative polarity, and in edge mode it can also catch both edges. A detected event sets that pin's bit in a capture register. Software clears a capture bit by writing 1 to it. A separate per-pin enable mask gates the capture bits into one combined interrupt line for the whole port. A capture bit can be pending while its enable is off, and it raises the line as soon as the enable is set.

Reads are combinational from the address, so read data is valid in the same cycle. Writes take effect at the next clock edge.

Top module: `pio_port32`

## Requirements
- R1: After reset every register is zero: the output, direction, sense, polarity, both-edge, capture and enable registers. `pin_out`, `pin_oe` and `irq` are 0.
- R2: A write to 0x00 loads the output register, which drives `pin_out`. A write to 0x08 loads the direction register, which drives `pin_oe` (1 = output). Both take effect at the next edge, and both read back at their own address.
- R3: Writing 1 to a bit at 0x40 (set) or 0x44 (clear) sets or clears that output bit. Writing 1 to a bit at 0x48 (set) or 0x4C (clear) does the same for the direction bit. Bits written as 0 leave their register bits unchanged.
- R4: A read at 0x04 returns the pin levels after two clock edges of synchronisation. A write to 0x04 changes no register.
- R5: When a pin's bit at 0x2C is 0, the pin uses edge sensing. In that mode a polarity bit at 0x18 of 0 detects a rising edge and 1 detects a falling edge. The capture bit becomes visible after the third clock edge that follows the pin change.
- R6: A pin in edge mode with its bit at 0x1C set to 1 and its polarity bit at 0 detects both rising and falling edges.
- R7: When a pin's bit at 0x2C is 1, the pin uses level sensing. A polarity bit of 0 makes a high level active and 1 makes a low level active. The capture bit is set again on every cycle the active level lasts, so a clear succeeds only once the level is gone.
- R8: The capture register is at 0x20. Writing 1 to a bit clears it and writing 0 leaves it unchanged. An edge-mode capture bit stays set until it is cleared. If an event and a clear hit the same bit in the same cycle, the event wins.
- R9: Writing 1 to a bit at 0x30 sets that pin's interrupt enable, and writing 1 to a bit at 0x34 clears it. Bits written as 0 have no effect. Reading either address returns the enable mask.
- R10: `irq` is the OR over all pins of capture AND enable. A capture bit that is pending while its enable is off raises `irq` in the cycle after the enable is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pin_in | input | 32 | Raw pin levels, asynchronous |
| pin_out | output | 32 | Output levels |
| pin_oe | output | 32 | Output drive enables |
| irq | output | 1 | Combined port interrupt |

## Verification
Register writes become visible one edge after the write strobe. A read of the synchronised input changes two edges after a pin change, and a capture bit changes three edges after it. `irq` follows a change to the capture or enable bits in the same cycle that change appears. The bench drives every stimulus one time unit after a rising edge and counts whole edges before each read. At the input read it checks both the stale value one edge early and the new value on time. At the capture register it checks that the bit is still clear two edges after the pin change and set on the third edge. It repeats this for each pin under all five sense settings.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int REG_AW = 8;

    typedef enum logic [REG_AW-1:0] {
        RG_DOUT  = 8'h00,
        RG_DIN   = 8'h04,
        RG_DIR   = 8'h08,
        RG_POL   = 8'h18,
        RG_BOTH  = 8'h1C,
        RG_CAP   = 8'h20,
        RG_MODE  = 8'h2C,
        RG_ENSET = 8'h30,
        RG_ENCLR = 8'h34,
        RG_OSET  = 8'h40,
        RG_OCLR  = 8'h44,
        RG_DSET  = 8'h48,
        RG_DCLR  = 8'h4C
    } reg_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= raw;
            stage2_q <= stage1_q;
        end
    end

    assign synced = stage2_q;
endmodule

// File: rtl/pio_detect.sv
module pio_detect #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] lvl,
    input  logic [PINS-1:0] mode,
    input  logic [PINS-1:0] pol,
    input  logic [PINS-1:0] both,
    output logic [PINS-1:0] ev
);
    logic [PINS-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        logic rise;
        logic fall;
        logic edge_hit;
        assign rise     = lvl[i] & ~prev_q[i];
        assign fall     = ~lvl[i] & prev_q[i];
        assign edge_hit = (both[i] & ~pol[i]) ? (rise | fall)
                        : (pol[i] ? fall : rise);
        assign ev[i]    = mode[i] ? (lvl[i] ^ pol[i]) : edge_hit;
    end

    // R5: an edge-mode event only appears when the synchronised level moved
    p_edge_needs_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev & ~mode & ~(lvl ^ prev_q)) == '0));
endmodule

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [PINS-1:0]   wdata,
    input  logic [PINS-1:0]   din,
    input  logic [PINS-1:0]   ev,
    output logic [PINS-1:0]   rdata,
    output logic [PINS-1:0]   dout_q,
    output logic [PINS-1:0]   dir_q,
    output logic [PINS-1:0]   mode_q,
    output logic [PINS-1:0]   pol_q,
    output logic [PINS-1:0]   both_q,
    output logic [PINS-1:0]   cap_q,
    output logic [PINS-1:0]   en_q
);
    logic [PINS-1:0] cap_clr;
    logic            cap_wr;

    assign cap_wr  = wr_en && (addr == RG_CAP);
    assign cap_clr = cap_wr ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
            dir_q  <= '0;
            mode_q <= '0;
            pol_q  <= '0;
            both_q <= '0;
            cap_q  <= '0;
            en_q   <= '0;
        end else begin
            cap_q <= (cap_q & ~cap_clr) | ev;
            if (wr_en) begin
                unique case (addr)
                    RG_DOUT:  dout_q <= wdata;
                    RG_DIR:   dir_q  <= wdata;
                    RG_POL:   pol_q  <= wdata;
                    RG_BOTH:  both_q <= wdata;
                    RG_MODE:  mode_q <= wdata;
                    RG_ENSET: en_q   <= en_q | wdata;
                    RG_ENCLR: en_q   <= en_q & ~wdata;
                    RG_OSET:  dout_q <= dout_q | wdata;
                    RG_OCLR:  dout_q <= dout_q & ~wdata;
                    RG_DSET:  dir_q  <= dir_q | wdata;
                    RG_DCLR:  dir_q  <= dir_q & ~wdata;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (addr)
            RG_DOUT:  rdata = dout_q;
            RG_DIN:   rdata = din;
            RG_DIR:   rdata = dir_q;
            RG_POL:   rdata = pol_q;
            RG_BOTH:  rdata = both_q;
            RG_CAP:   rdata = cap_q;
            RG_MODE:  rdata = mode_q;
            RG_ENSET: rdata = en_q;
            RG_ENCLR: rdata = en_q;
            default:  rdata = '0;
        endcase
    end

    p_out_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RG_OSET) |=> ((dout_q & $past(wdata)) == $past(wdata)));
    p_out_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RG_OCLR) |=> ((dout_q & $past(wdata)) == '0));
    p_dir_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RG_DSET) |=> ((dir_q & $past(wdata)) == $past(wdata)));
    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_wr |=> ((cap_q & $past(wdata & ~ev)) == '0));
    p_cap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_wr |=> ((cap_q & $past(cap_q)) == $past(cap_q)));
    p_en_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RG_ENSET) |=> ((en_q & $past(wdata)) == $past(wdata)));
endmodule

// File: rtl/pio_port32.sv
module pio_port32
    import pio_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [PINS-1:0]   wdata,
    output logic [PINS-1:0]   rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq
);
    logic [PINS-1:0] din;
    logic [PINS-1:0] ev;
    logic [PINS-1:0] mode_q;
    logic [PINS-1:0] pol_q;
    logic [PINS-1:0] both_q;
    logic [PINS-1:0] cap_q;
    logic [PINS-1:0] en_q;

    pio_sync #(.W(PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pin_in),
        .synced (din)
    );

    pio_detect #(.PINS(PINS)) u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (din),
        .mode  (mode_q),
        .pol   (pol_q),
        .both  (both_q),
        .ev    (ev)
    );

    pio_regs #(.PINS(PINS)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .din    (din),
        .ev     (ev),
        .rdata  (rdata),
        .dout_q (pin_out),
        .dir_q  (pin_oe),
        .mode_q (mode_q),
        .pol_q  (pol_q),
        .both_q (both_q),
        .cap_q  (cap_q),
        .en_q   (en_q)
    );

    assign irq = |(cap_q & en_q);

    // R10: the line only rises after a register write or a fresh event
    p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(wr_en) || ($past(ev) != '0)));
endmodule

// File: tb/pio_port32_bench.sv
module pio_port32_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pio_port32 u_pio_port32 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] exp_out;
        logic [31:0] exp_dir;
        logic [7:0]  addrs [9] = '{8'h00, 8'h04, 8'h08, 8'h18, 8'h1C, 8'h20, 8'h2C, 8'h30, 8'h34};
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        foreach (addrs[k]) begin
            rd(addrs[k], v);
            chk("R1 reg", v, 32'h0);
        end
        chk("R1 pin_out", pin_out, 32'h0);
        chk("R1 pin_oe", pin_oe, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // R2 whole-word writes
        wr(8'h00, 32'hA5A5_0F0F);
        chk("R2 pin_out", pin_out, 32'hA5A5_0F0F);
        rd(8'h00, v); chk("R2 dout read", v, 32'hA5A5_0F0F);
        wr(8'h08, 32'h3C3C_F00F);
        chk("R2 pin_oe", pin_oe, 32'h3C3C_F00F);
        rd(8'h08, v); chk("R2 dir read", v, 32'h3C3C_F00F);

        // R3 set/clear aliases, per pin
        exp_out = 32'hA5A5_0F0F;
        exp_dir = 32'h3C3C_F00F;
        for (int p = 0; p < 32; p++) begin
            wr(8'h40, 32'h1 << p); exp_out |= (32'h1 << p);
            chk("R3 out set", pin_out, exp_out);
            wr(8'h48, 32'h1 << ((p * 7) % 32)); exp_dir |= (32'h1 << ((p * 7) % 32));
            chk("R3 dir set", pin_oe, exp_dir);
        end
        for (int p = 0; p < 32; p += 2) begin
            wr(8'h44, 32'h1 << p); exp_out &= ~(32'h1 << p);
            chk("R3 out clr", pin_out, exp_out);
            wr(8'h4C, 32'h1 << (31 - p)); exp_dir &= ~(32'h1 << (31 - p));
            chk("R3 dir clr", pin_oe, exp_dir);
        end
        wr(8'h40, 32'h0); chk("R3 zero set", pin_out, exp_out);
        wr(8'h44, 32'h0); chk("R3 zero clr", pin_out, exp_out);

        // R4 synchronised input
        pin_in = 32'hDEAD_BEEF;
        tick(1);
        rd(8'h04, v); chk("R4 din early", v, 32'h0);
        tick(1);
        rd(8'h04, v); chk("R4 din", v, 32'hDEAD_BEEF);
        wr(8'h04, 32'h1234_5678);
        rd(8'h04, v); chk("R4 din write ignored", v, 32'hDEAD_BEEF);
        rd(8'h00, v); chk("R4 dout untouched", v, exp_out);
        rd(8'h08, v); chk("R4 dir untouched", v, exp_dir);

        // R5..R10 sense sweep: 0 rise, 1 fall, 2 both, 3 high level, 4 low level
        for (int m = 0; m < 5; m++) begin
            logic lvl_mode, neg, bth;
            logic [31:0] idle;
            string tag;
            lvl_mode = (m >= 3);
            neg = (m == 1) || (m == 4);
            bth = (m == 2);
            tag = lvl_mode ? "R7" : (bth ? "R6" : "R5");
            idle = neg ? 32'hFFFF_FFFF : 32'h0;
            wr(8'h2C, {32{lvl_mode}});
            wr(8'h18, {32{neg}});
            wr(8'h1C, {32{bth}});
            pin_in = idle;
            tick(4);
            wr(8'h20, 32'hFFFF_FFFF);
            rd(8'h20, v); chk({tag, " idle clear"}, v, 32'h0);
            for (int p = 0; p < 32; p++) begin
                logic [31:0] b;
                b = 32'h1 << p;
                pin_in = idle ^ b;
                tick(2);
                rd(8'h20, v); chk({tag, " not yet"}, v, 32'h0);
                tick(1);
                rd(8'h20, v); chk({tag, " captured"}, v, b);
                chk("R10 irq masked", {31'h0, irq}, 32'h0);
                wr(8'h30, b);
                rd(8'h34, v); chk("R9 enable set", v, b);
                chk("R10 irq pending", {31'h0, irq}, 32'h1);
                wr(8'h30, 32'h0);
                rd(8'h30, v); chk("R9 zero set", v, b);
                wr(8'h34, b);
                rd(8'h30, v); chk("R9 enable clr", v, 32'h0);
                chk("R10 irq off", {31'h0, irq}, 32'h0);
                wr(8'h20, ~b);
                rd(8'h20, v); chk("R8 zero bits", v, b);
                wr(8'h20, b);
                rd(8'h20, v); chk(lvl_mode ? "R7 reasserted" : "R8 cleared", v, lvl_mode ? b : 32'h0);
                pin_in = idle;
                tick(3);
                rd(8'h20, v); chk({tag, " return"}, v, (lvl_mode || bth) ? b : 32'h0);
                wr(8'h20, 32'hFFFF_FFFF);
                rd(8'h20, v); chk("R8 final clear", v, 32'h0);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule